// File: doc/BRIEF.md
# Serial Control Front End for a Four-Channel Digital Potentiometer

This block is the serial slave interface of a four-channel digital potentiometer controller. A host frames each command with an active-low select line. It shifts a command byte and, for most commands, a data byte into the serial input. Read results come back on the serial output. The block holds one 8-bit volatile wiper register per channel; these registers drive the tap position of the analog ladder that sits outside this block. It also holds one 8-bit data register per channel, which stands in for nonvolatile storage.

Every external serial pin is brought into the system clock domain through a two-stage synchronizer, and the block then detects edges on the synchronized copies. The host's serial clock must therefore be several times slower than the system clock. Four devices can share one bus because each one compares the address field of the command against its two strap inputs.

A data-register write is held pending until the select line is released. At that point it commits and starts a busy period of fixed length, which models the internal nonvolatile write cycle. A write-protect input blocks data-register writes only. A hold input can freeze a transfer part way through, and the transfer later resumes from the same bit.

Top module: `pot_ctrl_if`

## Requirements
- R1: Serial input is sampled on rising serial-clock edges, MSB first. A frame is a command byte followed by a data byte. The command byte has the opcode in bits [7:4], the device address in [3:2] and the channel in [1:0]. The opcodes are 0xA read wiper, 0x2 write wiper, 0xB read data register, 0xC write data register and 0x5 copy data register to wiper.
- R2: A write-wiper frame changes the addressed wiper as soon as the 16th bit is sampled. `wiper_o[8*c+7:8*c]` carries channel c.
- R3: After the command byte of a matching read, the block drives the addressed register's bits on `so` MSB first, changing on falling serial-clock edges. `so_oe` is high only in that data phase, and it is low whenever select is high.
- R4: A command whose address field differs from `dev_addr` is ignored entirely. It writes nothing and `so_oe` stays low.
- R5: Every frame starts at a falling edge of select. If select rises before the frame is complete, nothing is written, and the next frame starts from bit 0.
- R6: A write-data-register frame commits only on the rising edge of select that follows it. `busy` then stays high for exactly BUSY_CYCLES system clocks, and `busy` never rises at any other time.
- R7: While `busy` is high, write-wiper, write-data-register and copy commands are ignored. Reads still work.
- R8: While `wp_n` is low, data-register writes have no effect and start no busy period. Wiper writes still take effect.
- R9: If `wp_n` goes low while select is low, the pending data write is cancelled, even if `wp_n` returns high before select rises. Once the busy period has started, `wp_n` has no effect on it.
- R10: Hold is entered by a falling edge of `hold_n` and left by a rising edge of `hold_n`, both while the serial clock is low. While held, serial-clock and serial-input activity is ignored and `so_oe` is low. After release the transfer continues from the bit where it stopped.
- R11: A copy command copies the channel's data register into its wiper once the 8th command bit is sampled. It needs no data byte.
- R12: After reset every wiper and data register holds RESET_TAP (default 0x80), `busy` is low and `so_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Host serial clock |
| cs_n | input | 1 | Active-low frame select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low transfer pause |
| wp_n | input | 1 | Active-low write protect for data registers |
| dev_addr | input | 2 | Device address straps |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` (low means high impedance) |
| busy | output | 1 | Internal data-register write in progress |
| wiper_o | output | 32 | Four 8-bit wiper positions, channel 0 in the low byte |

## Verification
A vector table first runs wiper writes with distinct bit patterns (0x11, 0xFE, 0x00, 0xA5) into different channels, each followed by a read-back. This separates channel decoding, bit order and the read path. The table also includes frames with a foreign address to show that they change nothing and never enable the output. Directed tests cover the data-register path: a commit that is held back until select rises, the exact busy length, writes issued during busy, write protect held low, and write protect pulsed mid-frame. Further directed tests pause a write and a read part way through with hold, cut a frame short, use the copy command, and move the address straps. Together these tell apart a design that restarts, drops or shifts bits from one that keeps its place.

// File: rtl/pot_if_pkg.sv
// Shared constants and opcode encodings for the potentiometer serial interface.
// Assumes an 8-bit command byte and 8-bit data byte per frame.
package pot_if_pkg;
    localparam int CMD_W  = 8;
    localparam int DATA_W = 8;
    localparam int CH_W   = 2;
    localparam int ADDR_W = 2;
    localparam int NUM_CH = 1 << CH_W;

    typedef enum logic [3:0] {
        OP_WR_WIP = 4'h2,
        OP_COPY   = 4'h5,
        OP_RD_WIP = 4'hA,
        OP_RD_DAT = 4'hB,
        OP_WR_DAT = 4'hC
    } op_t;
endpackage

// File: rtl/pot_sync.sv
// Two-stage synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent; RST_VAL gives the idle level per bit.
module pot_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // Move the pins through two flops into the clk domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pot_serial_engine.sv
// Serial framing engine: tracks select, hold and bit position, shifts in the
// command and data bytes, and shifts read data out on falling serial edges.
// Assumes synchronized inputs and a serial clock well below the system clock.
module pot_serial_engine
    import pot_if_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              cs_n_s,
    input  logic              si_s,
    input  logic              hold_n_s,
    input  logic [ADDR_W-1:0] dev_addr,
    input  logic [DATA_W-1:0] rd_word,
    output logic [3:0]        now_op,
    output logic [CH_W-1:0]   now_ch,
    output logic [3:0]        q_op,
    output logic [CH_W-1:0]   q_ch,
    output logic              cmd_stb,
    output logic              data_stb,
    output logic [DATA_W-1:0] data_byte,
    output logic              cs_rise,
    output logic              so,
    output logic              so_oe
);
    localparam int FRAME_BITS = CMD_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    logic              sclk_d, cs_d, hold_d, held;
    logic [CNT_W-1:0]  bit_cnt;
    logic [CMD_W-2:0]  shreg;
    logic [DATA_W-1:0] out_sh;
    logic              match_q, rd_phase, so_q;
    logic [CMD_W-1:0]  cmd_now;
    logic              sclk_rise, sclk_fall, cs_fall, active, addr_ok, take_bit;

    // Edge detection and decode of the byte currently completing.
    always_comb begin
        sclk_rise = sclk_s && !sclk_d;
        sclk_fall = !sclk_s && sclk_d;
        cs_fall   = !cs_n_s && cs_d;
        cs_rise   = cs_n_s && !cs_d;
        active    = !cs_n_s && !held;
        cmd_now   = {shreg, si_s};
        data_byte = {shreg, si_s};
        now_op    = cmd_now[7:4];
        now_ch    = cmd_now[CH_W-1:0];
        addr_ok   = (cmd_now[3:2] == dev_addr);
        take_bit  = sclk_rise && active && (bit_cnt < CNT_W'(FRAME_BITS));
        cmd_stb   = take_bit && (bit_cnt == CNT_W'(CMD_W - 1)) && addr_ok;
        data_stb  = take_bit && (bit_cnt == CNT_W'(FRAME_BITS - 1)) && match_q;
        so        = so_q;
        so_oe     = rd_phase && !cs_n_s && !held;
    end

    // Hold state: entered and left only while the serial clock is low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= 1'b0;
        end else if (cs_n_s) begin
            held <= 1'b0;
        end else if (!held && hold_d && !hold_n_s && !sclk_s) begin
            held <= 1'b1;
        end else if (held && !hold_d && hold_n_s && !sclk_s) begin
            held <= 1'b0;
        end
    end

    // Frame bookkeeping, input shifting and output shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d   <= 1'b0;
            cs_d     <= 1'b1;
            hold_d   <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
            out_sh   <= '0;
            match_q  <= 1'b0;
            rd_phase <= 1'b0;
            so_q     <= 1'b0;
            q_op     <= '0;
            q_ch     <= '0;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
            hold_d <= hold_n_s;
            if (cs_fall) begin
                bit_cnt  <= '0;
                match_q  <= 1'b0;
                rd_phase <= 1'b0;
            end else if (take_bit) begin
                shreg   <= cmd_now[CMD_W-2:0];
                bit_cnt <= bit_cnt + 1'b1;
                if (bit_cnt == CNT_W'(CMD_W - 1)) begin
                    match_q  <= addr_ok;
                    rd_phase <= addr_ok && (now_op == OP_RD_WIP || now_op == OP_RD_DAT);
                    out_sh   <= rd_word;
                    q_op     <= now_op;
                    q_ch     <= now_ch;
                end
            end else if (sclk_fall && active && rd_phase) begin
                so_q   <= out_sh[DATA_W-1];
                out_sh <= {out_sh[DATA_W-2:0], 1'b0};
            end
        end
    end

    // R10
    hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        held && $past(held) |-> $stable(bit_cnt));
    // R5
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s && $past(cs_n_s) |-> $stable(bit_cnt));
endmodule

// File: rtl/pot_reg_bank.sv
// Wiper and data register bank with pending data write, write protection
// and the fixed-length busy period that models the nonvolatile write.
// Assumes strobes from the serial engine are single-cycle pulses.
module pot_reg_bank
    import pot_if_pkg::*;
#(
    parameter int                BUSY_CYCLES = 1000,
    parameter logic [DATA_W-1:0] RESET_TAP   = 8'h80
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [3:0]                     now_op,
    input  logic [CH_W-1:0]                now_ch,
    input  logic [3:0]                     q_op,
    input  logic [CH_W-1:0]                q_ch,
    input  logic                           cmd_stb,
    input  logic                           data_stb,
    input  logic [DATA_W-1:0]              data_byte,
    input  logic                           cs_rise,
    input  logic                           cs_n_s,
    input  logic                           wp_n_s,
    output logic [DATA_W-1:0]              rd_word,
    output logic [NUM_CH-1:0][DATA_W-1:0]  wiper_q,
    output logic                           busy
);
    localparam int BC_W = $clog2(BUSY_CYCLES + 1);

    logic [NUM_CH-1:0][DATA_W-1:0] data_q;
    logic [BC_W-1:0]               busy_cnt;
    logic                          pend;
    logic [CH_W-1:0]               pend_ch;
    logic [DATA_W-1:0]             pend_val;

    // Read selection for the command byte just completing.
    always_comb begin
        busy    = (busy_cnt != '0);
        rd_word = (now_op == OP_RD_DAT) ? data_q[now_ch] : wiper_q[now_ch];
    end

    // Register updates, pending write tracking and busy countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wiper_q  <= {NUM_CH{RESET_TAP}};
            data_q   <= {NUM_CH{RESET_TAP}};
            busy_cnt <= '0;
            pend     <= 1'b0;
            pend_ch  <= '0;
            pend_val <= '0;
        end else begin
            if (busy) busy_cnt <= busy_cnt - 1'b1;
            if (cmd_stb && !busy && now_op == OP_COPY)
                wiper_q[now_ch] <= data_q[now_ch];
            if (data_stb && !busy) begin
                if (q_op == OP_WR_WIP) begin
                    wiper_q[q_ch] <= data_byte;
                end else if (q_op == OP_WR_DAT && wp_n_s) begin
                    pend     <= 1'b1;
                    pend_ch  <= q_ch;
                    pend_val <= data_byte;
                end
            end
            if (cs_rise) begin
                pend <= 1'b0;
                if (pend && wp_n_s && !busy) begin
                    data_q[pend_ch] <= pend_val;
                    busy_cnt        <= BC_W'(BUSY_CYCLES);
                end
            end else if (!cs_n_s && !wp_n_s) begin
                pend <= 1'b0;
            end
        end
    end

    // R6
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cs_rise));
    // R7
    busy_data_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(data_q));
    // R7
    busy_wiper_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && $past(busy) |-> $stable(wiper_q));
    // R8
    wp_data_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(data_q) |-> $past(wp_n_s));
endmodule

// File: rtl/pot_ctrl_if.sv
// Top of the potentiometer serial control interface: synchronizes the pins,
// runs the framing engine and holds the register bank.
// Assumes the serial clock is at least eight times slower than clk.
module pot_ctrl_if
    import pot_if_pkg::*;
#(
    parameter int                BUSY_CYCLES = 1000,
    parameter logic [DATA_W-1:0] RESET_TAP   = 8'h80
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sclk,
    input  logic                     cs_n,
    input  logic                     si,
    input  logic                     hold_n,
    input  logic                     wp_n,
    input  logic [ADDR_W-1:0]        dev_addr,
    output logic                     so,
    output logic                     so_oe,
    output logic                     busy,
    output logic [NUM_CH*DATA_W-1:0] wiper_o
);
    logic [4:0]                    pins_s;
    logic                          cmd_stb, data_stb, cs_rise;
    logic [3:0]                    now_op, q_op;
    logic [CH_W-1:0]               now_ch, q_ch;
    logic [DATA_W-1:0]             data_byte, rd_word;
    logic [NUM_CH-1:0][DATA_W-1:0] wiper_q;

    assign wiper_o = wiper_q;

    pot_sync #(.W(5), .RST_VAL(5'b11100)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .d({wp_n, hold_n, cs_n, si, sclk}),
        .q(pins_s)
    );

    pot_serial_engine u_engine (
        .clk(clk), .rst_n(rst_n),
        .sclk_s(pins_s[0]), .si_s(pins_s[1]), .cs_n_s(pins_s[2]),
        .hold_n_s(pins_s[3]), .dev_addr(dev_addr), .rd_word(rd_word),
        .now_op(now_op), .now_ch(now_ch), .q_op(q_op), .q_ch(q_ch),
        .cmd_stb(cmd_stb), .data_stb(data_stb), .data_byte(data_byte),
        .cs_rise(cs_rise), .so(so), .so_oe(so_oe)
    );

    pot_reg_bank #(.BUSY_CYCLES(BUSY_CYCLES), .RESET_TAP(RESET_TAP)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .now_op(now_op), .now_ch(now_ch), .q_op(q_op), .q_ch(q_ch),
        .cmd_stb(cmd_stb), .data_stb(data_stb), .data_byte(data_byte),
        .cs_rise(cs_rise), .cs_n_s(pins_s[2]), .wp_n_s(pins_s[4]),
        .rd_word(rd_word), .wiper_q(wiper_q), .busy(busy)
    );
endmodule

// File: tb/pot_ctrl_if_tb.sv
// Self-checking bench: a vector table of wiper frames, then directed tests.
module pot_ctrl_if_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int BUSY       = 700;
    localparam int NVEC       = 12;

    logic        clk = 0, rst_n = 0, sclk = 0, cs_n = 1, si = 0, hold_n = 1, wp_n = 1;
    logic [1:0]  dev_addr = 2'b10;
    logic        so, so_oe, busy;
    logic [31:0] wiper_o;
    int          checks = 0, failures = 0, busy_seen = 0;

    // {cmd, data, is_read, expected read byte, expected wipers}
    localparam logic [56:0] VECS [0:NVEC-1] = '{
        {8'h28, 8'h11, 1'b0, 8'h00, 32'h80808011},
        {8'h2B, 8'hFE, 1'b0, 8'h00, 32'hFE808011},
        {8'hAB, 8'h00, 1'b1, 8'hFE, 32'hFE808011},
        {8'hA8, 8'h00, 1'b1, 8'h11, 32'hFE808011},
        {8'h25, 8'h33, 1'b0, 8'h00, 32'hFE808011},
        {8'hA5, 8'h00, 1'b0, 8'h00, 32'hFE808011},
        {8'hA9, 8'h00, 1'b1, 8'h80, 32'hFE808011},
        {8'h29, 8'h00, 1'b0, 8'h00, 32'hFE800011},
        {8'hA9, 8'h00, 1'b1, 8'h00, 32'hFE800011},
        {8'h2A, 8'hA5, 1'b0, 8'h00, 32'hFEA50011},
        {8'hAA, 8'h00, 1'b1, 8'hA5, 32'hFEA50011},
        {8'hBA, 8'h00, 1'b1, 8'h80, 32'hFEA50011}
    };

    pot_ctrl_if #(.BUSY_CYCLES(BUSY)) u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .dev_addr(dev_addr),
        .so(so), .so_oe(so_oe), .busy(busy), .wiper_o(wiper_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (busy) busy_seen++;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One frame; hold_at < 0 means no pause, keep_low leaves select asserted.
    task automatic run_frame(input logic [7:0] c, input logic [7:0] d, input int nbits,
                             input int hold_at, input bit keep_low,
                             output logic [7:0] rd, output logic oe_all,
                             output logic oe_any, output logic oe_held);
        logic [15:0] word;
        word = {c, d};
        rd = 0; oe_all = 1; oe_any = 0; oe_held = 0;
        cs_n = 0;
        tick(HALF);
        for (int i = 0; i < nbits; i++) begin
            if (i == hold_at) begin
                tick(HALF);
                hold_n = 0;
                tick(HALF);
                for (int k = 0; k < 3; k++) begin
                    si = ~si; sclk = 1; tick(HALF);
                    if (so_oe) oe_held = 1;
                    sclk = 0; tick(HALF);
                    if (so_oe) oe_held = 1;
                end
                hold_n = 1;
                tick(HALF);
            end
            si = word[15-i];
            tick(HALF);
            if (i >= 8) begin
                rd = {rd[6:0], so};
                if (!so_oe) oe_all = 0;
            end
            if (so_oe) oe_any = 1;
            sclk = 1;
            tick(HALF);
            sclk = 0;
        end
        tick(HALF);
        if (!keep_low) begin
            cs_n = 1;
            tick(HALF);
        end
    endtask

    task automatic wait_idle();
        int guard;
        guard = 0;
        while (busy && guard < 5000) begin tick(1); guard++; end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic oe_all, oe_any, oe_held;
        tick(5);
        rst_n = 1;
        tick(3);
        // R12 reset state
        check("R12 wipers", wiper_o, 32'h80808080);
        check("R12 busy", {31'b0, busy}, 32'd0);
        check("R12 so_oe", {31'b0, so_oe}, 32'd0);

        // R1 R2 R3 R4 vector table
        for (int v = 0; v < NVEC; v++) begin
            run_frame(VECS[v][56:49], VECS[v][48:41], 16, -1, 0, rd, oe_all, oe_any, oe_held);
            tick(4);
            if (VECS[v][40]) begin
                check("R3 read enable", {31'b0, oe_all}, 32'd1);
                check("R1 R3 read data", {24'b0, rd}, {24'b0, VECS[v][39:32]});
            end else begin
                check("R4 no output enable", {31'b0, oe_any}, 32'd0);
            end
            check("R2 R4 wipers", wiper_o, VECS[v][31:0]);
        end

        // R6 commit deferred to select rise, exact busy length
        busy_seen = 0;
        run_frame(8'hC9, 8'h5A, 16, -1, 1, rd, oe_all, oe_any, oe_held);
        tick(10);
        check("R6 no busy before select rise", {31'b0, busy}, 32'd0);
        cs_n = 1;
        tick(6);
        check("R6 busy after select rise", {31'b0, busy}, 32'd1);
        // R9 write protect after start has no effect; R7 writes during busy ignored
        wp_n = 0; tick(10); wp_n = 1;
        run_frame(8'h28, 8'h77, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        run_frame(8'h59, 8'h00, 8, -1, 0, rd, oe_all, oe_any, oe_held);
        tick(4);
        check("R7 wipers unchanged during busy", wiper_o, 32'hFEA50011);
        wait_idle();
        check("R6 busy length", busy_seen, BUSY);
        run_frame(8'hB9, 8'h00, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        check("R6 R9 committed data", {24'b0, rd}, 32'h5A);

        // R8 write protect blocks data, allows wiper
        busy_seen = 0;
        wp_n = 0;
        tick(4);
        run_frame(8'hCA, 8'h3C, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        run_frame(8'h2A, 8'h44, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        tick(20);
        check("R8 no busy under protect", busy_seen, 0);
        check("R8 wiper write allowed", wiper_o, 32'hFE440011);
        wp_n = 1;
        tick(4);
        run_frame(8'hBA, 8'h00, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        check("R8 data unchanged", {24'b0, rd}, 32'h80);

        // R9 protect pulse while select low cancels
        busy_seen = 0;
        run_frame(8'hCB, 8'h99, 16, -1, 1, rd, oe_all, oe_any, oe_held);
        wp_n = 0; tick(6); wp_n = 1; tick(6);
        cs_n = 1;
        tick(20);
        check("R9 cancelled write no busy", busy_seen, 0);
        run_frame(8'hBB, 8'h00, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        check("R9 cancelled data unchanged", {24'b0, rd}, 32'h80);

        // R10 hold during a write and during a read
        run_frame(8'h2B, 8'h96, 16, 5, 0, rd, oe_all, oe_any, oe_held);
        tick(4);
        check("R10 write across hold", wiper_o, 32'h96440011);
        run_frame(8'hAB, 8'h00, 16, 11, 0, rd, oe_all, oe_any, oe_held);
        check("R10 read across hold", {24'b0, rd}, 32'h96);
        check("R10 output off while held", {31'b0, oe_held}, 32'd0);
        check("R10 output on outside hold", {31'b0, oe_all}, 32'd1);

        // R5 short frame ignored, next frame restarts
        run_frame(8'h28, 8'h3F, 12, -1, 0, rd, oe_all, oe_any, oe_held);
        tick(4);
        check("R5 partial frame ignored", wiper_o, 32'h96440011);
        run_frame(8'hA8, 8'h00, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        check("R5 restart after partial", {24'b0, rd}, 32'h11);

        // R11 copy data register to wiper
        run_frame(8'h59, 8'h00, 8, -1, 0, rd, oe_all, oe_any, oe_held);
        tick(4);
        check("R11 copy", wiper_o, 32'h96445A11);

        // R4 strap change
        dev_addr = 2'b01;
        tick(4);
        run_frame(8'h24, 8'h6B, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        run_frame(8'h28, 8'h01, 16, -1, 0, rd, oe_all, oe_any, oe_held);
        tick(4);
        check("R4 new strap match", wiper_o, 32'h96445A6B);
        check("R3 idle output off", {31'b0, so_oe}, 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule